// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block joins two eight-line prioritising interrupt controllers into one sixteen-input unit. Inputs 0 to 7 go to the primary controller and inputs 8 to 15 to the secondary. Input n lands on controller n>>3, line n&7. Whenever the secondary holds a request that beats its own in-service set, it raises a request on line 2 of the primary. The primary alone drives the interrupt output to the processor. The output is worked out again from the registered state after every input change, register write, acknowledge and poll read.

Software reaches the unit through a byte-wide register bus. Each controller has two registers, chosen by address bit 0: an even one for init and command words, an odd one for init data and the mask. A third pair of addresses holds the per-controller trigger-select registers. Each of these decides, per line, whether the line is edge- or level-sensitive. Each has a fixed set of bits that can be written.

The processor takes an interrupt with a one-cycle acknowledge strobe. On the next cycle the block returns an eight-bit vector and a valid flag. The vector is the upper five bits of the programmed base followed by the three-bit line number. When the primary's winner is the cascade line, the secondary is acknowledged and its base and line are used. When a controller has nothing to give, line 7 is returned as a spurious value.

Top module: `pic_pair`

## Requirements
- R1: Input n is routed to controller n>>3, line n&7. An edge-sensitive line latches a request only on a 0-to-1 change of its input, so a line held high does not request again after it has been acknowledged.
- R2: On a level-sensitive line the request bit follows the input level. Acknowledge does not clear it, so the request is still there after end-of-interrupt while the input stays high, and it goes away when the input falls.
- R3: Byte address 0x4D0 holds the primary's trigger-select register and 0x4D1 the secondary's. A 1 bit means level-sensitive. A write is ANDed with 0xF8 on the primary and 0xDE on the secondary. Both reset to 0 (all lines edge-sensitive).
- R4: Addresses 0x20/0x21 select the primary and 0xA0/0xA1 the secondary, with bit 0 choosing the even or odd register. An access whose byte flag is low has no effect. A read of an unmapped address returns 0. Read data appears on the cycle after the read strobe.
- R5: An even-register write with bit 4 set starts initialisation. It clears mask, request, in-service, rotation and modes, and drops the interrupt output. The next odd write sets the vector base to data[7:3]. One more odd write follows. A fourth odd write follows only when bit 0 of the first word was set: its bit 1 selects auto end-of-interrupt and its bit 4 selects special nested mode. After that, odd writes load the mask (1 = line masked).
- R6: A pending request on the secondary sets the primary's line 2 request. A primary acknowledge or a secondary poll hit that clears that bit wins over the cascade set in the same cycle.
- R7: One cycle after an acknowledge strobe, the valid flag is high for one cycle and the vector is ready. If the primary's winner is a line other than 2, the vector is primary base plus line. If the winner is line 2, it is secondary base plus the secondary's line, or plus 7 when the secondary has nothing. If the primary has no request, it is primary base plus 7.
- R8: Priority goes to the lowest line number after rotation, which starts at line 0 first. A request raises the output only if it outranks every line in service. A non-specific end-of-interrupt (even write 0x20) clears the highest-priority in-service bit.
- R9: Even write with data[7:5]=011 clears in-service bit data[2:0]. 110 makes line data[2:0] the lowest priority. 111 does both. 101 is a non-specific end-of-interrupt that also rotates. 100/000 turn rotation on auto end-of-interrupt on or off.
- R10: An even write with data[3]=1 and data[1]=1 picks what even reads return: the in-service bits when data[0]=1, the request bits when data[0]=0. Odd reads return the mask.
- R11: An even write with data[3]=1 and data[2]=1 arms a poll. The next read of that controller returns the winning line number, or 7 when there is none, and clears that line's request and in-service bits. A poll hit on the secondary also clears the primary's line 2 request and in-service bits.
- R12: In auto end-of-interrupt mode an acknowledge sets no in-service bit, so later requests are not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Interrupt request inputs |
| bus_addr | input | 16 | Byte address of the register access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_byte | input | 1 | High when the access is one byte wide |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| ack | input | 1 | Interrupt acknowledge strobe |
| int_out | output | 1 | Interrupt request to the processor |
| vec | output | 8 | Vector returned for the last acknowledge |
| vec_valid | output | 1 | One-cycle flag marking vec as new |

## Verification
The hardest state to reach is the primary holding a request on line 2 that comes only from the secondary, and then having that request removed by a poll read on the secondary instead of by an acknowledge. The bench raises a secondary input and waits the two register stages it takes for the cascade bit to show up on the interrupt output. It then arms a poll on the secondary and reads it. After that it checks both the returned line and that the output and the primary's request bits fall. Rotated priority and level-sensitive lines are reached by programming the command and trigger-select registers before driving the inputs.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int LINES    = 8;
    localparam int LW       = $clog2(LINES);
    localparam int NCTL     = 2;
    localparam int NIRQ     = LINES * NCTL;
    localparam int DW       = 8;
    localparam int AW       = 16;
    localparam int BASE_W   = DW - LW;
    localparam int CAS_LINE = 2;
    localparam logic [LW:0]   NO_PRIO   = LW'(0) | (1 << LW);
    localparam logic [LW-1:0] SPUR_LINE = LW'(LINES - 1);

    localparam logic [AW-1:0] ADDR_CTL0 = 16'h0020;
    localparam logic [AW-1:0] ADDR_CTL1 = 16'h00A0;
    localparam logic [AW-1:0] ADDR_TRIG = 16'h04D0;
    localparam logic [DW-1:0] TMASK0    = 8'hF8;
    localparam logic [DW-1:0] TMASK1    = 8'hDE;

    typedef enum logic [1:0] {
        IS_READY = 2'd0,
        IS_W2    = 2'd1,
        IS_W3    = 2'd2,
        IS_W4    = 2'd3
    } istate_e;

    typedef struct packed {
        logic [LINES-1:0] irr;
        logic [LINES-1:0] imr;
        logic [LINES-1:0] isr;
        logic [LINES-1:0] last;
        logic [LW-1:0]    rot;
        logic [BASE_W-1:0] base;
        logic             rsel;
        logic             poll;
        istate_e          istate;
        logic             need4;
        logic             aeoi;
        logic             rot_aeoi;
        logic             sfn;
    } ctl_t;

    typedef struct packed {
        logic          valid;
        logic [LW-1:0] line;
    } req_t;

    function automatic logic [AW-1:0] ctl_addr(input int idx);
        return (idx == 0) ? ADDR_CTL0 : ADDR_CTL1;
    endfunction

    function automatic logic [DW-1:0] trig_mask(input int idx);
        return (idx == 0) ? TMASK0 : TMASK1;
    endfunction

    // Priority index (0 = best) of the first set bit after rotation; NO_PRIO if empty.
    function automatic logic [LW:0] prio_of(input logic [LINES-1:0] m, input logic [LW-1:0] rot);
        logic [LW:0]   r;
        logic [LW-1:0] idx;
        r = NO_PRIO;
        for (int p = LINES - 1; p >= 0; p--) begin
            idx = LW'(p) + rot;
            if (m[idx]) r = (LW + 1)'(p);
        end
        return r;
    endfunction

endpackage

// File: rtl/pic_unit.sv
module pic_unit
    import pic_pkg::*;
#(
    parameter logic [DW-1:0] TRIG_MASK  = 8'hFF,
    parameter bit            IS_PRIMARY = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  line_lvl,
    input  logic              cas_set,
    input  logic              cas_clr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              reg_sel,
    input  logic [DW-1:0]     wdata,
    input  logic              trig_wr,
    input  logic              ack_en,
    output req_t              req,
    output logic [BASE_W-1:0] base,
    output logic [DW-1:0]     rd_val,
    output logic [DW-1:0]     trig,
    output logic              poll_hit
);

    ctl_t st, nx;
    logic [LW:0]      pp, cp, ip;
    logic [LINES-1:0] pend, svc;
    logic [LW-1:0]    ln;

    // Request resolution against the in-service set
    always_comb begin
        pend = st.irr & ~st.imr;
        svc  = st.isr;
        if (IS_PRIMARY && st.sfn) svc[CAS_LINE] = 1'b0;
        pp = prio_of(pend, st.rot);
        cp = prio_of(svc, st.rot);
        req.valid = (pp != NO_PRIO) && (pp < cp);
        req.line  = pp[LW-1:0] + st.rot;
    end

    assign base     = st.base;
    assign poll_hit = rd_en && st.poll && req.valid;

    always_comb begin
        if (st.poll)       rd_val = req.valid ? DW'(req.line) : DW'(SPUR_LINE);
        else if (reg_sel)  rd_val = st.imr;
        else if (st.rsel)  rd_val = st.isr;
        else               rd_val = st.irr;
    end

    always_comb begin
        nx = st;
        ip = NO_PRIO;
        ln = '0;
        // input sampling
        for (int i = 0; i < LINES; i++) begin
            if (trig[i])                           nx.irr[i] = line_lvl[i];
            else if (line_lvl[i] && !st.last[i])   nx.irr[i] = 1'b1;
        end
        nx.last = line_lvl;
        if (IS_PRIMARY && cas_set) nx.irr[CAS_LINE] = 1'b1;
        // acknowledge
        if (ack_en) begin
            if (st.aeoi) begin
                if (st.rot_aeoi) nx.rot = req.line + LW'(1);
            end else begin
                nx.isr[req.line] = 1'b1;
            end
            if (!trig[req.line]) nx.irr[req.line] = 1'b0;
        end
        // poll read
        if (rd_en && st.poll) begin
            nx.poll = 1'b0;
            if (req.valid) begin
                nx.irr[req.line] = 1'b0;
                nx.isr[req.line] = 1'b0;
            end
        end
        if (IS_PRIMARY && cas_clr) begin
            nx.irr[CAS_LINE] = 1'b0;
            nx.isr[CAS_LINE] = 1'b0;
        end
        // register writes
        if (wr_en && !reg_sel) begin
            if (wdata[4]) begin
                nx        = '0;
                nx.istate = IS_W2;
                nx.need4  = wdata[0];
            end else if (wdata[3]) begin
                if (wdata[2]) nx.poll = 1'b1;
                if (wdata[1]) nx.rsel = wdata[0];
            end else begin
                case (wdata[7:5])
                    3'd0, 3'd4: nx.rot_aeoi = wdata[7];
                    3'd1, 3'd5: begin
                        ip = prio_of(st.isr, st.rot);
                        if (ip != NO_PRIO) begin
                            ln = ip[LW-1:0] + st.rot;
                            nx.isr[ln] = 1'b0;
                            if (wdata[7]) nx.rot = ln + LW'(1);
                        end
                    end
                    3'd3: nx.isr[wdata[LW-1:0]] = 1'b0;
                    3'd6: nx.rot = wdata[LW-1:0] + LW'(1);
                    3'd7: begin
                        nx.isr[wdata[LW-1:0]] = 1'b0;
                        nx.rot = wdata[LW-1:0] + LW'(1);
                    end
                    default: ;
                endcase
            end
        end else if (wr_en && reg_sel) begin
            case (st.istate)
                IS_READY: nx.imr = wdata;
                IS_W2: begin
                    nx.base   = wdata[DW-1:LW];
                    nx.istate = IS_W3;
                end
                IS_W3: nx.istate = st.need4 ? IS_W4 : IS_READY;
                IS_W4: begin
                    nx.sfn    = wdata[4];
                    nx.aeoi   = wdata[1];
                    nx.istate = IS_READY;
                end
                default: nx.istate = IS_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nx;
    end

    always_ff @(posedge clk) begin
        if (rst)          trig <= '0;
        else if (trig_wr) trig <= wdata & TRIG_MASK;
    end

    AST_REQ_HAS_PEND: assert property (@(posedge clk) disable iff (rst)
        req.valid |-> ((st.irr & ~st.imr) != '0));  // R8
    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack_en && !st.aeoi && !wr_en && !rd_en && !cas_clr) |=> st.isr[$past(req.line)]);  // R7
    AST_CAS_CLR_ISR: assert property (@(posedge clk) disable iff (rst)
        (IS_PRIMARY && cas_clr) |=> !st.isr[CAS_LINE]);  // R11

endmodule

// File: rtl/pic_pair.sv
module pic_pair
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] irq_in,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic            bus_byte,
    output logic [DW-1:0]   bus_rdata,
    input  logic            ack,
    output logic            int_out,
    output logic [DW-1:0]   vec,
    output logic            vec_valid
);

    logic [NCTL-1:0]   u_hit, u_thit, u_ack, u_poll;
    req_t              u_req  [NCTL];
    logic [BASE_W-1:0] u_base [NCTL];
    logic [DW-1:0]     u_rdv  [NCTL];
    logic [DW-1:0]     u_trig [NCTL];
    logic [DW-1:0]     rdata_d, vec_d;

    generate
        for (genvar g = 0; g < NCTL; g++) begin : g_ctl
            assign u_hit[g]  = bus_byte && ({bus_addr[AW-1:1], 1'b0} == ctl_addr(g));
            assign u_thit[g] = bus_byte && (bus_addr == ADDR_TRIG + AW'(g));

            pic_unit #(
                .TRIG_MASK  (trig_mask(g)),
                .IS_PRIMARY (g == 0)
            ) u_ctl (
                .clk      (clk),
                .rst      (rst),
                .line_lvl (irq_in[g*LINES +: LINES]),
                .cas_set  ((g == 0) ? u_req[NCTL-1].valid : 1'b0),
                .cas_clr  ((g == 0) ? u_poll[NCTL-1] : 1'b0),
                .wr_en    (bus_wr && u_hit[g]),
                .rd_en    (bus_rd && u_hit[g]),
                .reg_sel  (bus_addr[0]),
                .wdata    (bus_wdata),
                .trig_wr  (bus_wr && u_thit[g]),
                .ack_en   (u_ack[g]),
                .req      (u_req[g]),
                .base     (u_base[g]),
                .rd_val   (u_rdv[g]),
                .trig     (u_trig[g]),
                .poll_hit (u_poll[g])
            );
        end
    endgenerate

    assign int_out  = u_req[0].valid;
    assign u_ack[0] = ack && u_req[0].valid;
    assign u_ack[1] = u_ack[0] && (u_req[0].line == LW'(CAS_LINE)) && u_req[1].valid;

    always_comb begin
        if (!u_req[0].valid)
            vec_d = {u_base[0], SPUR_LINE};
        else if (u_req[0].line != LW'(CAS_LINE))
            vec_d = {u_base[0], u_req[0].line};
        else if (u_req[1].valid)
            vec_d = {u_base[1], u_req[1].line};
        else
            vec_d = {u_base[1], SPUR_LINE};
    end

    always_comb begin
        rdata_d = '0;
        for (int i = 0; i < NCTL; i++) begin
            if (u_hit[i])  rdata_d = u_rdv[i];
            if (u_thit[i]) rdata_d = u_trig[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            vec       <= '0;
            vec_valid <= 1'b0;
        end else begin
            if (bus_rd) bus_rdata <= rdata_d;
            vec_valid <= ack;
            if (ack) vec <= vec_d;
        end
    end

    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack));  // R7
    AST_SPUR_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_out) |=> (vec[LW-1:0] == SPUR_LINE));  // R7
    AST_INIT_DROPS_INT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && u_hit[0] && !bus_addr[0] && bus_wdata[4]) |=> !int_out);  // R5
    AST_POLL_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        (u_poll != '0) |-> bus_rd);  // R11

endmodule

// File: tb/pic_pair_tb.sv
module pic_pair_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_in = '0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_byte = 1'b1, ack = 1'b0;
    logic [7:0]  bus_rdata, vec;
    logic        int_out, vec_valid;
    int          checks = 0, errors = 0;

    always #2 clk = ~clk;

    pic_pair u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_byte(bus_byte), .bus_rdata(bus_rdata), .ack(ack),
        .int_out(int_out), .vec(vec), .vec_valid(vec_valid)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic one = 1'b1);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_byte = one;
        @(negedge clk);
        bus_wr = 1'b0; bus_byte = 1'b1;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_ack(output logic [7:0] v);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk({7'd0, vec_valid}, 8'd1, "R7 valid flag after acknowledge");
        v = vec;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk({7'd0, int_out}, 8'd0, "R5 reset output low");
        rd(16'h04D0, d); chk(d, 8'h00, "R3 trigger select resets to zero");
        rd(16'h0020, d); chk(d, 8'h00, "R10 request bits zero after reset");
    endtask

    task automatic t_init;
        wr(16'h0020, 8'h11); wr(16'h0021, 8'h08); wr(16'h0021, 8'h04); wr(16'h0021, 8'h01);
        wr(16'h00A0, 8'h11); wr(16'h00A1, 8'h70); wr(16'h00A1, 8'h02); wr(16'h00A1, 8'h01);
    endtask

    task automatic t_edge;
        logic [7:0] v;
        irq_in[1] = 1'b1; idle(2);
        chk({7'd0, int_out}, 8'd1, "R1 rising edge raises output");
        do_ack(v); chk(v, 8'h09, "R7 primary vector base plus line");
        wr(16'h0020, 8'h20); idle(2);
        chk({7'd0, int_out}, 8'd0, "R1 held-high edge line not re-requested");
        irq_in[1] = 1'b0; idle(1);
    endtask

    task automatic t_cascade;
        logic [7:0] v;
        irq_in[10] = 1'b1; idle(3);
        chk({7'd0, int_out}, 8'd1, "R6 secondary request reaches output");
        do_ack(v); chk(v, 8'h72, "R7 cascade vector from secondary");
        wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20); idle(2);
        chk({7'd0, int_out}, 8'd0, "R6 cascade request consumed by acknowledge");
        irq_in[10] = 1'b0; idle(1);
    endtask

    task automatic t_spurious;
        logic [7:0] v;
        do_ack(v); chk(v, 8'h0F, "R7 spurious primary vector");
    endtask

    task automatic t_trig_bus;
        logic [7:0] d;
        wr(16'h04D0, 8'hFF); rd(16'h04D0, d); chk(d, 8'hF8, "R3 primary trigger mask");
        wr(16'h04D1, 8'hFF); rd(16'h04D1, d); chk(d, 8'hDE, "R3 secondary trigger mask");
        wr(16'h04D0, 8'h00, 1'b0); rd(16'h04D0, d); chk(d, 8'hF8, "R4 non-byte write ignored");
        rd(16'h0300, d); chk(d, 8'h00, "R4 unmapped read returns zero");
        wr(16'h04D1, 8'h00); wr(16'h04D0, 8'h00);
    endtask

    task automatic t_level;
        logic [7:0] v;
        wr(16'h04D0, 8'h08);
        irq_in[3] = 1'b1; idle(2);
        do_ack(v); chk(v, 8'h0B, "R2 level line vector");
        wr(16'h0020, 8'h20); idle(2);
        chk({7'd0, int_out}, 8'd1, "R2 level request survives acknowledge");
        irq_in[3] = 1'b0; idle(2);
        chk({7'd0, int_out}, 8'd0, "R2 level request follows input low");
        wr(16'h04D0, 8'h00);
    endtask

    task automatic t_priority;
        logic [7:0] v, d;
        irq_in[4] = 1'b1; irq_in[5] = 1'b1; idle(2);
        do_ack(v); chk(v, 8'h0C, "R8 lower line number wins");
        idle(1); chk({7'd0, int_out}, 8'd0, "R8 in-service line blocks lower priority");
        wr(16'h0020, 8'h0B); rd(16'h0020, d); chk(d, 8'h10, "R10 in-service readback");
        wr(16'h0020, 8'h20); idle(1);
        chk({7'd0, int_out}, 8'd1, "R8 non-specific EOI releases pending");
        do_ack(v); chk(v, 8'h0D, "R8 next line served");
        wr(16'h0020, 8'h20);
        irq_in[4] = 1'b0; irq_in[5] = 1'b0; idle(1);
    endtask

    task automatic t_rotate;
        logic [7:0] v;
        wr(16'h0020, 8'hC4);
        irq_in[1] = 1'b1; irq_in[6] = 1'b1; idle(2);
        do_ack(v); chk(v, 8'h0E, "R9 set-priority rotation picks line 6");
        idle(1); chk({7'd0, int_out}, 8'd0, "R9 line 1 ranks below line 6");
        wr(16'h0020, 8'h66); idle(1);
        chk({7'd0, int_out}, 8'd1, "R9 specific EOI clears line 6");
        do_ack(v); chk(v, 8'h09, "R9 line 1 served after");
        wr(16'h0020, 8'h61); wr(16'h0020, 8'hC7);
        irq_in[1] = 1'b0; irq_in[6] = 1'b0; idle(1);
    endtask

    task automatic t_poll;
        logic [7:0] d;
        irq_in[13] = 1'b1; idle(3);
        chk({7'd0, int_out}, 8'd1, "R6 secondary line 5 cascades");
        wr(16'h00A0, 8'h0C); rd(16'h00A0, d); chk(d, 8'h05, "R11 poll returns line");
        idle(1); chk({7'd0, int_out}, 8'd0, "R11 poll clears cascade request");
        wr(16'h0020, 8'h0A); rd(16'h0020, d); chk(d, 8'h00, "R11 primary line 2 request cleared");
        wr(16'h0020, 8'h0C); rd(16'h0020, d); chk(d, 8'h07, "R11 empty poll returns 7");
        irq_in[13] = 1'b0; idle(1);
    endtask

    task automatic t_mask;
        logic [7:0] v, d;
        wr(16'h0021, 8'h02);
        irq_in[1] = 1'b1; idle(2);
        chk({7'd0, int_out}, 8'd0, "R5 masked line held off");
        rd(16'h0021, d); chk(d, 8'h02, "R10 mask readback");
        wr(16'h0021, 8'h00); idle(1);
        chk({7'd0, int_out}, 8'd1, "R5 unmasked line raises output");
        do_ack(v); chk(v, 8'h09, "R5 unmasked vector");
        wr(16'h0020, 8'h20);
        wr(16'h0021, 8'h02);
        irq_in[1] = 1'b0; idle(1);
    endtask

    task automatic t_aeoi;
        logic [7:0] v, d;
        wr(16'h0020, 8'h11); wr(16'h0021, 8'h20); wr(16'h0021, 8'h04); wr(16'h0021, 8'h03);
        rd(16'h0021, d); chk(d, 8'h00, "R5 init clears mask");
        irq_in[0] = 1'b1; idle(2);
        do_ack(v); chk(v, 8'h20, "R5 new base used");
        wr(16'h0020, 8'h0B); rd(16'h0020, d); chk(d, 8'h00, "R12 auto EOI leaves no in-service bit");
        irq_in[0] = 1'b0; irq_in[1] = 1'b1; idle(2);
        chk({7'd0, int_out}, 8'd1, "R12 later request not blocked");
        irq_in[1] = 1'b0; idle(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_init();
        t_edge();
        t_cascade();
        t_spurious();
        t_trig_bus();
        t_level();
        t_priority();
        t_rotate();
        t_poll();
        t_mask();
        t_aeoi();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule